// File: doc/BRIEF.md
# Instruction Fetch Sequencer

This block is the fetch slice of a small 16-bit processor. It owns the program counter, the memory address register, the memory data register and the instruction register. It steps through the fetch states and stops at the entry to decode. In the first fetch state the program counter is placed on an internal shared bus. The address register captures it and the program counter advances by one. The block then issues a memory read and waits for the memory side to reply with a ready signal.

While it waits, the data register reloads from the read-data input on every cycle. The word present on the cycle that ready is sampled high is therefore the one that stays. In the next state the data register drives the shared bus and the instruction register loads from it. The sequencer then parks in the decode state, raises `decode_valid` and holds all of its registers until reset.

The memory address output always shows the address register, so it needs no enable. Writes, interrupts and execution of the fetched instruction are handled elsewhere.

Top module: `fetch_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `state_out` is 18, `pc_out` is 16'h0200, `mem_addr` and `ir_out` are 0, and `mio_en` and `decode_valid` are 0.
- R2: In state 18 the address register takes the program counter, the program counter increments by 1, and the next state is 33 whatever `mem_ready` is.
- R3: `mio_en` is 1 and `mio_wr` is 0 in every cycle of state 33. `mio_en` is 0 in states 18, 35 and 32.
- R4: In state 33 the state stays 33 on each edge where `mem_ready` is 0. It becomes 35 on the edge where `mem_ready` is 1, so with a ready delay of d cycles, decode (32) is reached 3+d edges after reset release.
- R5: The data register loads `mem_rdata` on every edge in state 33. Words present before ready is sampled high are overwritten and do not reach `ir_out`.
- R6: In state 35 the instruction register loads the data register's word through the shared bus, and the next state is 32.
- R7: State 32 is terminal. `decode_valid` is 1, and `state_out`, `ir_out`, `pc_out` and `mem_addr` stay unchanged, with `mem_ready` ignored.
- R8: `mem_addr` always equals the address register. During the read it carries the fetched address 16'h0200.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | AW | Memory address from the address register |
| mem_rdata | input | DW | Memory read data |
| mio_en | output | 1 | Memory-IO request enable |
| mio_wr | output | 1 | Access direction, 0 = read |
| mem_ready | input | 1 | Memory-IO ready reply |
| pc_out | output | AW | Program counter |
| ir_out | output | DW | Instruction register |
| state_out | output | 6 | Sequencer state number (18, 33, 35, 32) |
| decode_valid | output | 1 | High while in decode state 32 |

## Verification
The assertions check the following on every cycle: the state ordering, the wait in state 33 while ready is low, the one-step advance of the program counter, the transfer of the word sampled with ready into the instruction register two edges later, and the hold in decode. Only the bench scenarios can show that the fetched word is exactly the stored one across varied ready delays. They also show that data presented before ready is discarded, that an early or permanent ready does not disturb the sequence, and that a reset in the middle of the read restores the start values.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  // State numbers are visible on state_out and are kept fixed.
  typedef enum logic [5:0] {
    ST_ADDR   = 6'd18,
    ST_DECODE = 6'd32,
    ST_READ   = 6'd33,
    ST_XFER   = 6'd35
  } fstate_t;

  // Per-state control word from sequencer to datapath.
  typedef struct packed {
    logic gate_pc;
    logic gate_mdr;
    logic ld_pc;
    logic ld_mar;
    logic ld_mdr;
    logic ld_ir;
    logic mio_en;
    logic mio_wr;
  } ctl_t;

  localparam int unsigned NUM_BUS_SRC = 2;
  localparam int unsigned SRC_PC  = 0;
  localparam int unsigned SRC_MDR = 1;

endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    mem_ready,
  output fstate_t state,
  output ctl_t    ctl,
  output logic    decode_valid
);

  fstate_t nxt;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_ADDR;
    else     state <= nxt;
  end

  always_comb begin
    nxt = state;
    ctl = '0;
    unique case (state)
      ST_ADDR: begin
        ctl.gate_pc = 1'b1;
        ctl.ld_mar  = 1'b1;
        ctl.ld_pc   = 1'b1;
        nxt         = ST_READ;
      end
      ST_READ: begin
        ctl.mio_en = 1'b1;
        ctl.mio_wr = 1'b0;
        ctl.ld_mdr = 1'b1;
        if (mem_ready) nxt = ST_XFER;
      end
      ST_XFER: begin
        ctl.gate_mdr = 1'b1;
        ctl.ld_ir    = 1'b1;
        nxt          = ST_DECODE;
      end
      ST_DECODE: nxt = ST_DECODE;
      default:   nxt = ST_ADDR;
    endcase
  end

  assign decode_valid = (state == ST_DECODE);

endmodule

// File: rtl/fetch_bus.sv
module fetch_bus #(
  parameter int unsigned DW   = 16,
  parameter int unsigned NSRC = 2
) (
  input  logic [NSRC-1:0]         gate,
  input  logic [NSRC-1:0][DW-1:0] src,
  output logic [DW-1:0]           bus
);

  logic [NSRC-1:0][DW-1:0] masked;

  // Each driver contributes only while gated, like a tri-state buffer.
  for (genvar i = 0; i < NSRC; i++) begin : g_drv
    assign masked[i] = gate[i] ? src[i] : '0;
  end

  always_comb begin
    bus = '0;
    for (int i = 0; i < NSRC; i++) bus = bus | masked[i];
  end

endmodule

// File: rtl/fetch_regs.sv
module fetch_regs
  import fetch_pkg::*;
#(
  parameter int unsigned          AW       = 16,
  parameter int unsigned          DW       = 16,
  parameter logic [AW-1:0]        RESET_PC = 16'h0200
) (
  input  logic          clk,
  input  logic          rst,
  input  ctl_t          ctl,
  input  logic [DW-1:0] bus,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] mar,
  output logic [DW-1:0] mdr,
  output logic [DW-1:0] ir
);

  localparam logic [AW-1:0] PC_STEP = AW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= RESET_PC;
      mar <= '0;
      mdr <= '0;
      ir  <= '0;
    end else begin
      if (ctl.ld_pc)  pc  <= pc + PC_STEP;
      if (ctl.ld_mar) mar <= bus[AW-1:0];
      if (ctl.ld_mdr) mdr <= mem_rdata;
      if (ctl.ld_ir)  ir  <= bus;
    end
  end

endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
  import fetch_pkg::*;
#(
  parameter int unsigned   AW       = 16,
  parameter int unsigned   DW       = 16,
  parameter logic [AW-1:0] RESET_PC = 16'h0200
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          mio_en,
  output logic          mio_wr,
  input  logic          mem_ready,
  output logic [AW-1:0] pc_out,
  output logic [DW-1:0] ir_out,
  output logic [5:0]    state_out,
  output logic          decode_valid
);

  fstate_t state;
  ctl_t    ctl;
  logic [DW-1:0] bus;
  logic [AW-1:0] pc, mar;
  logic [DW-1:0] mdr, ir;
  logic [NUM_BUS_SRC-1:0]         gate;
  logic [NUM_BUS_SRC-1:0][DW-1:0] src;

  fetch_ctrl i_ctrl (
    .clk(clk), .rst(rst), .mem_ready(mem_ready),
    .state(state), .ctl(ctl), .decode_valid(decode_valid)
  );

  assign gate[SRC_PC]  = ctl.gate_pc;
  assign gate[SRC_MDR] = ctl.gate_mdr;
  assign src[SRC_PC]   = DW'(pc);
  assign src[SRC_MDR]  = mdr;

  fetch_bus #(.DW(DW), .NSRC(NUM_BUS_SRC)) i_bus (
    .gate(gate), .src(src), .bus(bus)
  );

  fetch_regs #(.AW(AW), .DW(DW), .RESET_PC(RESET_PC)) i_regs (
    .clk(clk), .rst(rst), .ctl(ctl), .bus(bus), .mem_rdata(mem_rdata),
    .pc(pc), .mar(mar), .mdr(mdr), .ir(ir)
  );

  assign mem_addr  = mar;
  assign mio_en    = ctl.mio_en;
  assign mio_wr    = ctl.mio_wr;
  assign pc_out    = pc;
  assign ir_out    = ir;
  assign state_out = state;

endmodule

// File: rtl/fetch_seq_chk.sv
module fetch_seq_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_rdata,
  input logic          mio_en,
  input logic          mem_ready,
  input logic [AW-1:0] pc_out,
  input logic [DW-1:0] ir_out,
  input logic [5:0]    state_out
);

  p_addr_to_read_r2: assert property (@(posedge clk) disable iff (rst)
    state_out == 6'd18 |=> state_out == 6'd33);

  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    state_out == 6'd18 |=> pc_out == $past(pc_out) + AW'(1) && mem_addr == $past(pc_out));

  p_req_start_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(mio_en) |-> $past(state_out) == 6'd18);

  p_wait_r4: assert property (@(posedge clk) disable iff (rst)
    state_out == 6'd33 && !mem_ready |=> state_out == 6'd33 && $stable(mem_addr));

  p_advance_r4: assert property (@(posedge clk) disable iff (rst)
    state_out == 6'd33 && mem_ready |=> state_out == 6'd35);

  p_ir_word_r6: assert property (@(posedge clk) disable iff (rst)
    state_out == 6'd33 && mem_ready |=> ##1 ir_out == $past(mem_rdata, 2) && state_out == 6'd32);

  p_decode_hold_r7: assert property (@(posedge clk) disable iff (rst)
    state_out == 6'd32 |=> state_out == 6'd32 && $stable(ir_out) && $stable(pc_out) && !mio_en);

endmodule

bind fetch_seq fetch_seq_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
  .mio_en(mio_en), .mem_ready(mem_ready), .pc_out(pc_out),
  .ir_out(ir_out), .state_out(state_out)
);

// File: tb/test_fetch_seq.sv
module test_fetch_seq;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam logic [15:0] START = 16'h0200;
  localparam int NVEC = 6;
  // Each entry: {ready delay[7:0], stored word[15:0]}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'd0, 16'h14C5}, {8'd1, 16'hBEEF}, {8'd2, 16'h0000},
    {8'd5, 16'hFFFF}, {8'd9, 16'h5A3C}, {8'd3, 16'h8001}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] mem_addr, pc_out;
  logic [DW-1:0] mem_rdata, ir_out;
  logic mio_en, mio_wr, mem_ready, decode_valid;
  logic [5:0] state_out;

  int   tests = 0;
  int   fails = 0;
  logic [7:0]  cfg_delay = 8'd0;
  logic [15:0] cfg_word  = 16'h0000;
  logic        force_ready = 1'b0;
  int          cnt = 0;

  always #5 clk = ~clk;

  fetch_seq #(.AW(AW), .DW(DW)) i_fetch_seq (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mio_en(mio_en), .mio_wr(mio_wr), .mem_ready(mem_ready),
    .pc_out(pc_out), .ir_out(ir_out), .state_out(state_out),
    .decode_valid(decode_valid)
  );

  // Memory model: ready after cfg_delay request cycles; junk data until then.
  always @(posedge clk) begin
    if (rst || !mio_en) cnt <= 0;
    else                cnt <= cnt + 1;
  end
  assign mem_ready = force_ready | (mio_en && (cnt >= int'(cfg_delay)));
  assign mem_rdata = (mem_ready && mem_addr == START) ? cfg_word : (cfg_word ^ 16'hA5A5);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_fetch(input logic [7:0] d, input logic [15:0] w);
    int n = 0;
    int bad_req = 0;
    cfg_delay = d;
    cfg_word  = w;
    do_reset();
    while (!decode_valid && n < 300) begin
      @(negedge clk);
      n++;
      if (state_out == 6'd33) begin
        if (!(mio_en && !mio_wr && mem_addr == START)) bad_req++;
      end else if (mio_en) bad_req++;
    end
    chk(n == 3 + int'(d), "R4 edges to decode", n, 3 + int'(d));
    chk(ir_out == w, "R5/R6 fetched word", ir_out, w);
    chk(pc_out == START + 16'd1, "R2 pc advanced", pc_out, START + 16'd1);
    chk(bad_req == 0, "R3/R8 request and address", bad_req, 0);
  endtask

  initial begin
    // R1: reset state
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(state_out == 6'd18, "R1 state", state_out, 18);
    chk(pc_out == START, "R1 pc", pc_out, START);
    chk(ir_out == 16'h0 && mem_addr == 16'h0, "R1 ir/addr", {ir_out, mem_addr}, 0);
    chk(!mio_en && !decode_valid, "R1 req/valid", {mio_en, decode_valid}, 0);

    for (int i = 0; i < NVEC; i++) run_fetch(VEC[i][23:16], VEC[i][15:0]);

    // R7: decode is terminal, ready ignored
    force_ready = 1'b1;
    repeat (6) @(negedge clk);
    chk(state_out == 6'd32 && decode_valid, "R7 stays in decode", state_out, 32);
    chk(ir_out == 16'h8001 && pc_out == START + 16'd1 && !mio_en, "R7 regs held", ir_out, 16'h8001);

    // R2: ready high from the start does not skip the address state
    run_fetch(8'd0, 16'h3C3C);
    force_ready = 1'b0;

    // R1: reset in the middle of a long read
    cfg_delay = 8'd50;
    do_reset();
    repeat (5) @(negedge clk);
    chk(state_out == 6'd33 && mio_en, "R4 waiting", state_out, 33);
    rst = 1'b1;
    @(negedge clk);
    chk(state_out == 6'd18 && pc_out == START && ir_out == 16'h0, "R1 mid-read reset", state_out, 18);
    chk(!mio_en, "R1 mid-read reset req", mio_en, 0);
    rst = 1'b0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule